// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block monitors a single active-low external interrupt pin and keeps the pending flag that an interrupt controller samples. A mode input chooses how the pin is judged. In edge mode a falling transition latches the flag, and it stays set until the controller acknowledges the vector. In level mode nothing is latched: the flag is a registered copy of the inverted, synchronized pin.

The pin passes through a two-flop synchronizer first. After that a one-cycle history register finds falling transitions. In edge mode, software can also load the flag through a write strobe. Priority resolution and vector generation belong to the interrupt controller, not to this block.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset is released, `pend_o` and `irq_o` are 0 until a trigger condition is seen.
- R2: A change on `pin_ni` reaches `pend_o` on the third rising clock edge after the change, and not earlier. The pin passes through two synchronizer flops and the flag register.
- R3: When `trig_edge_i` = 1 (edge mode), a synchronized high sample followed by a low sample sets `pend_o`. The flag stays set after the pin returns high.
- R4: In edge mode, `ack_i` high for one cycle clears `pend_o` at the next clock edge.
- R5: In edge mode, when a falling edge is detected in the same cycle as `ack_i`, `pend_o` stays set.
- R6: When `trig_edge_i` = 0 (level mode), `pend_o` follows the inverse of the synchronized pin, and `ack_i` has no effect on it.
- R7: In level mode, the write strobe `flag_we_i` has no effect on `pend_o`.
- R8: In edge mode, `flag_we_i` loads `flag_wd_i` into `pend_o` at the next edge. A falling edge detected in the same cycle wins over a write of 0, and a write wins over `ack_i`.
- R9: When the mode switches from level to edge, `pend_o` keeps its value until the next falling edge, acknowledge or write.
- R10: `irq_o` always equals `pend_o`.
- R11: In edge mode, a pin held low produces exactly one event. After an acknowledge the flag stays clear while the pin remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_ni | input | 1 | External interrupt pin, active low, asynchronous |
| trig_edge_i | input | 1 | 1 = falling-edge trigger, 0 = low-level trigger |
| ack_i | input | 1 | Vector acknowledge strobe from the interrupt controller |
| flag_we_i | input | 1 | Software write strobe for the flag |
| flag_wd_i | input | 1 | Value for a software write |
| pend_o | output | 1 | Interrupt pending flag |
| irq_o | output | 1 | Interrupt request to the controller |

## Verification
The hardest case to reach from the ports is a falling edge that lands in the same cycle as an acknowledge. The detection pulse lasts one cycle, and it only exists two edges after the pin drops. The bench first sets the flag with an earlier edge and returns the pin high. It then drops the pin on a falling clock edge, waits exactly two rising edges, and raises `ack_i` for the one cycle in which the detection pulse is present. The flag must survive, even though an acknowledge alone would clear it. The same timing is reused to pit a detected edge against a write of 0.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam logic        PIN_IDLE        = 1'b1;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= IDLE;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{IDLE}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/ext_irq_fall_det.sv
module ext_irq_fall_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= pin_s_i;
  end

  assign fall_o = prev_q & ~pin_s_i;

  // a detection pulse never lasts two cycles
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R11
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag
  import ext_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic fall_i,
  input  logic mode_i,
  input  logic ack_i,
  input  logic we_i,
  input  logic wd_i,
  output logic flag_o
);
  trig_mode_e mode;
  logic       flag_q, flag_d;

  assign mode = trig_mode_e'(mode_i);

  always_comb begin
    flag_d = flag_q;
    if (mode == TRIG_LEVEL) begin
      flag_d = ~pin_s_i;
    end else begin
      if (fall_i)     flag_d = 1'b1;   // edge wins so no event is lost
      else if (we_i)  flag_d = wd_i;
      else if (ack_i) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && fall_i) |=> flag_o); // R3
  AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && ack_i && !fall_i && !we_i) |=> !flag_o); // R4
  AST_LEVEL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i) |=> (flag_o == !$past(pin_s_i))); // R6
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !fall_i && !ack_i && !we_i) |=> $stable(flag_o)); // R9
  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && we_i && !fall_i) |=> (flag_o == $past(wd_i))); // R8
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic trig_edge_i,
  input  logic ack_i,
  input  logic flag_we_i,
  input  logic flag_wd_i,
  output logic pend_o,
  output logic irq_o
);
  logic pin_s;
  logic fall;
  logic flag;

  ext_irq_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_ni),
    .q_o    (pin_s)
  );

  ext_irq_fall_det #(
    .IDLE (PIN_IDLE)
  ) u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_s_i (pin_s),
    .fall_o  (fall)
  );

  ext_irq_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_s_i (pin_s),
    .fall_i  (fall),
    .mode_i  (trig_edge_i),
    .ack_i   (ack_i),
    .we_i    (flag_we_i),
    .wd_i    (flag_wd_i),
    .flag_o  (flag)
  );

  assign pend_o = flag;
  assign irq_o  = flag;

  AST_IRQ_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == pend_o); // R10
  AST_ACK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_edge_i && ack_i && !pend_o && pin_s) |=> !pend_o); // R6
endmodule

// File: tb/ext_irq_detect_bench.sv
`timescale 1ns/1ps
module ext_irq_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1, edge_m = 1'b1, ack = 1'b0, we = 1'b0, wd = 1'b0;
  logic pend, irq;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_detect u_ext_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_ni(pin_n), .trig_edge_i(edge_m),
    .ack_i(ack), .flag_we_i(we), .flag_wd_i(wd), .pend_o(pend), .irq_o(irq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic got, logic exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle_high();
    pin_n = 1'b1; step(4);
  endtask

  task automatic t_reset();
    chk(pend, 1'b0, "R1 pend after reset");
    chk(irq, 1'b0, "R1 irq after reset");
  endtask

  task automatic t_edge_latch();
    edge_m = 1'b1; settle_high();
    pin_n = 1'b0;
    step(2); chk(pend, 1'b0, "R2 not before third edge");
    step(1); chk(pend, 1'b1, "R2/R3 set on third edge");
    chk(irq, 1'b1, "R10 irq follows pend");
    pin_n = 1'b1; step(4);
    chk(pend, 1'b1, "R3 held after pin high");
    ack = 1'b1; step(1); ack = 1'b0;
    chk(pend, 1'b0, "R4 ack clears");
    chk(irq, 1'b0, "R10 irq clears");
  endtask

  task automatic t_held_low();
    edge_m = 1'b1; settle_high();
    pin_n = 1'b0; step(3);
    chk(pend, 1'b1, "R11 first event");
    ack = 1'b1; step(1); ack = 1'b0;
    step(5);
    chk(pend, 1'b0, "R11 no re-trigger while low");
    settle_high();
  endtask

  task automatic t_ack_collide();
    edge_m = 1'b1; settle_high();
    we = 1'b1; wd = 1'b1; step(1); we = 1'b0;
    chk(pend, 1'b1, "R8 write sets");
    pin_n = 1'b0; step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    chk(pend, 1'b1, "R5 edge beats ack");
    settle_high();
    ack = 1'b1; step(1); ack = 1'b0;
    chk(pend, 1'b0, "R5 later ack clears");
  endtask

  task automatic t_write();
    edge_m = 1'b1; settle_high();
    we = 1'b1; wd = 1'b1; step(1);
    wd = 1'b0; step(1); we = 1'b0;
    chk(pend, 1'b0, "R8 write clears");
    we = 1'b1; wd = 1'b1; ack = 1'b1; step(1); we = 1'b0; ack = 1'b0;
    chk(pend, 1'b1, "R8 write beats ack");
    we = 1'b1; wd = 1'b0; step(1); we = 1'b0;
    pin_n = 1'b0; step(2);
    we = 1'b1; wd = 1'b0; step(1); we = 1'b0;
    chk(pend, 1'b1, "R8 edge beats write 0");
    settle_high();
    we = 1'b1; wd = 1'b0; step(1); we = 1'b0;
  endtask

  task automatic t_level();
    edge_m = 1'b0; pin_n = 1'b1; step(3);
    chk(pend, 1'b0, "R6 level high pin");
    pin_n = 1'b0; step(2);
    chk(pend, 1'b0, "R2 level latency");
    step(1); chk(pend, 1'b1, "R6 level low pin");
    ack = 1'b1; step(3); ack = 1'b0;
    chk(pend, 1'b1, "R6 ack ignored");
    we = 1'b1; wd = 1'b0; step(1); we = 1'b0;
    chk(pend, 1'b1, "R7 write 0 ignored");
    pin_n = 1'b1; step(3);
    chk(pend, 1'b0, "R6 tracks release");
    we = 1'b1; wd = 1'b1; step(1); we = 1'b0;
    chk(pend, 1'b0, "R7 write 1 ignored");
  endtask

  task automatic t_switch();
    edge_m = 1'b0; pin_n = 1'b0; step(4);
    chk(pend, 1'b1, "R9 level set");
    edge_m = 1'b1; pin_n = 1'b1; step(5);
    chk(pend, 1'b1, "R9 held after switch");
    ack = 1'b1; step(1); ack = 1'b0;
    chk(pend, 1'b0, "R9 ack after switch");
  endtask

  initial begin
    step(2); rst_n = 1'b1; step(2);
    t_reset();
    t_edge_latch();
    t_held_low();
    t_ack_collide();
    t_write();
    t_level();
    t_switch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule